// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block is the stall controller that sits between the fetch and decode stages of an in-order, five-stage integer pipeline. It looks at the instruction now in decode and at the one now in execute. If the execute instruction is a load whose destination register is a source of the decode instruction, the value cannot reach execute in time even with forwarding. The controller then holds the front end for one cycle and sends an empty control word down the pipe. Once that single bubble has passed, the load result can be forwarded as usual.

The block contains working models of the program counter, the fetch/decode instruction latch and the control part of the decode/execute latch, so the effect of a stall can be seen over several cycles. A small two-state machine tracks whether the previous cycle was a stall. Its states are `ST_RUN` (normal flow, stall allowed) and `ST_REFILL` (the bubble is in execute). It has two transitions: `ST_RUN` -> `ST_REFILL` when a hazard is detected, and `ST_REFILL` -> `ST_RUN` unconditionally. Instruction fields are taken from fixed positions: opcode in bits 31:26, first source (rs) in bits 25:21, second source / load destination (rt) in bits 20:16.

Top module: `load_use_interlock`

## Requirements
- R1: While `rst_n` is low, `pc_addr` is 0, `ifid_instr` is 0 and all four execute control outputs are 0.
- R2: A stall (`pc_wr_en`=0, `ifid_wr_en`=0, `ctrl_zero`=1) is signalled in a cycle exactly when `idex_mem_rd` is 1 and `idex_rt` equals bits 25:21 or bits 20:16 of `ifid_instr`. Register number 0 gets no special treatment.
- R3: After a stalled cycle, `pc_addr` and `ifid_instr` keep their values, so the dependent instruction is decoded again and the next word is fetched again.
- R4: After a stalled cycle, all execute control outputs are 0 (a no-op bubble).
- R5: A stall never lasts longer than one cycle. The cycle after a stall never stalls.
- R6: In a cycle without a stall, `pc_addr` advances by 4 at the next rising edge and `ifid_instr` takes the value of `fetch_word`.
- R7: Decode of a non-bubble word, as seen in the execute outputs one cycle later: opcode 35 (load) sets mem_rd, reg_wr and mem_to_reg; opcode 43 (store) sets only mem_wr; opcode 0 with a non-zero word sets only reg_wr; `idex_rt` carries bits 20:16.
- R8: The all-zero word is a no-op: it produces all-zero execute controls, and an unknown opcode does the same.
- R9: The state machine moves from `ST_RUN` to `ST_REFILL` on a detected hazard and always returns to `ST_RUN` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_word | input | 32 | Instruction word read at `pc_addr` |
| pc_addr | output | PC_W | Current program counter |
| pc_wr_en | output | 1 | PC update enable for the coming edge |
| ifid_wr_en | output | 1 | Fetch/decode latch update enable |
| ctrl_zero | output | 1 | Forces the control word entering execute to zero |
| ifid_instr | output | 32 | Instruction held in decode |
| idex_mem_rd | output | 1 | Execute-stage memory read control |
| idex_mem_wr | output | 1 | Execute-stage memory write control |
| idex_reg_wr | output | 1 | Execute-stage register write control |
| idex_mem_to_reg | output | 1 | Execute-stage load result select |
| idex_rt | output | 5 | rt field of the execute-stage instruction |

## Verification
The assertions check on every cycle that a held cycle leaves the PC and decode latch unchanged, that a free cycle steps the PC by 4 and captures the fetched word, that a bubble produces an empty control word, and that a stall is never followed by another. Whether a stall is raised for the right register pairs, and only for loads, can only be shown by the bench. It sweeps every combination of load destination and both consumer sources over a small register range, for loads, stores and ALU producers. The bench's own scenarios also cover a consumer two slots after the load, which must not stall, and a chain of dependent loads that stalls twice but not back to back.

// File: rtl/lu_pkg.sv
package lu_pkg;

    localparam int IW     = 32;
    localparam int REG_AW = 5;
    localparam int OPC_HI = 31;
    localparam int OPC_LO = 26;
    localparam int RS_HI  = 25;
    localparam int RS_LO  = 21;
    localparam int RT_HI  = 20;
    localparam int RT_LO  = 16;
    localparam int OPC_W  = OPC_HI - OPC_LO + 1;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'd43;
    localparam logic [OPC_W-1:0] OPC_ALU   = 6'd0;

    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_REFILL = 1'b1
    } il_state_t;

    typedef struct packed {
        logic mem_rd;
        logic mem_wr;
        logic reg_wr;
        logic mem_to_reg;
    } ex_ctrl_t;

    function automatic ex_ctrl_t decode_ctrl(input logic [IW-1:0] word);
        ex_ctrl_t c;
        c = '0;
        case (word[OPC_HI:OPC_LO])
            OPC_LOAD: begin
                c.mem_rd     = 1'b1;
                c.reg_wr     = 1'b1;
                c.mem_to_reg = 1'b1;
            end
            OPC_STORE: c.mem_wr = 1'b1;
            OPC_ALU:   c.reg_wr = |word;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lu_detect.sv
module lu_detect
    import lu_pkg::*;
(
    input  logic              idex_mem_rd,
    input  logic [REG_AW-1:0] idex_rt,
    input  logic [REG_AW-1:0] ifid_rs,
    input  logic [REG_AW-1:0] ifid_rt,
    output logic              hazard
);
    localparam int NSRC = 2;

    logic [NSRC-1:0][REG_AW-1:0] src;
    logic [NSRC-1:0]             hit;

    assign src[0] = ifid_rs;
    assign src[1] = ifid_rt;

    for (genvar s = 0; s < NSRC; s++) begin : g_cmp
        assign hit[s] = (src[s] == idex_rt);
    end

    assign hazard = idex_mem_rd && (|hit);

endmodule

// File: rtl/lu_stall_fsm.sv
module lu_stall_fsm
    import lu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic pc_we,
    output logic ifid_we,
    output logic bubble
);
    il_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pc_we   = 1'b1;
        ifid_we = 1'b1;
        bubble  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (hazard) begin
                    state_d = ST_REFILL;
                    pc_we   = 1'b0;
                    ifid_we = 1'b0;
                    bubble  = 1'b1;
                end
            end
            ST_REFILL: begin
                state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // R5: a bubble in execute clears the load, so no hazard can follow
    assert_no_second_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL) |-> !hazard);

    assert_enter_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hazard && state_q == ST_RUN) |=> (state_q == ST_REFILL));

    assert_leave_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL) |=> (state_q == ST_RUN));

endmodule

// File: rtl/lu_front_end.sv
module lu_front_end
    import lu_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    input  logic            ifid_we,
    input  logic [IW-1:0]   fetch_word,
    output logic [PC_W-1:0] pc_q,
    output logic [IW-1:0]   ifid_q
);
    localparam logic [PC_W-1:0] STEP_V = PC_W'(PC_STEP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pc_q <= '0;
        else if (pc_we) pc_q <= pc_q + STEP_V;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ifid_q <= '0;
        else if (ifid_we) ifid_q <= fetch_word;
    end

    assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> $stable(pc_q));

    assert_ifid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ifid_we |=> $stable(ifid_q));

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> (pc_q == $past(pc_q) + STEP_V));

    assert_ifid_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_we |=> (ifid_q == $past(fetch_word)));

endmodule

// File: rtl/lu_idex_stage.sv
module lu_idex_stage
    import lu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bubble,
    input  logic [IW-1:0]     ifid_word,
    output ex_ctrl_t          ctrl_q,
    output logic [REG_AW-1:0] rt_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            rt_q   <= '0;
        end else begin
            ctrl_q <= bubble ? ex_ctrl_t'('0) : decode_ctrl(ifid_word);
            rt_q   <= ifid_word[RT_HI:RT_LO];
        end
    end

    assert_bubble_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bubble |=> (ctrl_q == '0));

    assert_load_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!bubble && ifid_word[OPC_HI:OPC_LO] == OPC_LOAD) |=> (ctrl_q.mem_rd && !ctrl_q.mem_wr));

    assert_nop_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ifid_word == '0) |=> (ctrl_q == '0));

endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
    import lu_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IW-1:0]     fetch_word,
    output logic [PC_W-1:0]   pc_addr,
    output logic              pc_wr_en,
    output logic              ifid_wr_en,
    output logic              ctrl_zero,
    output logic [IW-1:0]     ifid_instr,
    output logic              idex_mem_rd,
    output logic              idex_mem_wr,
    output logic              idex_reg_wr,
    output logic              idex_mem_to_reg,
    output logic [REG_AW-1:0] idex_rt
);
    logic     hazard;
    ex_ctrl_t ex_ctrl;

    lu_front_end #(.PC_W(PC_W), .PC_STEP(PC_STEP)) u_front (
        .clk        (clk),
        .rst_n      (rst_n),
        .pc_we      (pc_wr_en),
        .ifid_we    (ifid_wr_en),
        .fetch_word (fetch_word),
        .pc_q       (pc_addr),
        .ifid_q     (ifid_instr)
    );

    lu_detect u_detect (
        .idex_mem_rd (ex_ctrl.mem_rd),
        .idex_rt     (idex_rt),
        .ifid_rs     (ifid_instr[RS_HI:RS_LO]),
        .ifid_rt     (ifid_instr[RT_HI:RT_LO]),
        .hazard      (hazard)
    );

    lu_stall_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .hazard  (hazard),
        .pc_we   (pc_wr_en),
        .ifid_we (ifid_wr_en),
        .bubble  (ctrl_zero)
    );

    lu_idex_stage u_idex (
        .clk       (clk),
        .rst_n     (rst_n),
        .bubble    (ctrl_zero),
        .ifid_word (ifid_instr),
        .ctrl_q    (ex_ctrl),
        .rt_q      (idex_rt)
    );

    assign idex_mem_rd     = ex_ctrl.mem_rd;
    assign idex_mem_wr     = ex_ctrl.mem_wr;
    assign idex_reg_wr     = ex_ctrl.reg_wr;
    assign idex_mem_to_reg = ex_ctrl.mem_to_reg;

    assert_single_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_zero |=> !ctrl_zero);

    assert_stall_needs_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_mem_rd |-> (pc_wr_en && ifid_wr_en && !ctrl_zero));

endmodule

// File: tb/test_load_use_interlock.sv
module test_load_use_interlock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_word;
    logic [31:0] pc_addr;
    logic        pc_wr_en, ifid_wr_en, ctrl_zero;
    logic [31:0] ifid_instr;
    logic        idex_mem_rd, idex_mem_wr, idex_reg_wr, idex_mem_to_reg;
    logic [4:0]  idex_rt;

    logic [31:0] prog [0:7];
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    always_comb fetch_word = prog[pc_addr[4:2]];

    load_use_interlock i_load_use_interlock (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .pc_addr(pc_addr),
        .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en), .ctrl_zero(ctrl_zero),
        .ifid_instr(ifid_instr), .idex_mem_rd(idex_mem_rd), .idex_mem_wr(idex_mem_wr),
        .idex_reg_wr(idex_reg_wr), .idex_mem_to_reg(idex_mem_to_reg), .idex_rt(idex_rt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_load(int rs, int rt);
        return {6'd35, 5'(rs), 5'(rt), 16'h0010};
    endfunction
    function automatic logic [31:0] mk_store(int rs, int rt);
        return {6'd43, 5'(rs), 5'(rt), 16'h0020};
    endfunction
    function automatic logic [31:0] mk_alu(int rs, int rt);
        return {6'd0, 5'(rs), 5'(rt), 5'd9, 5'd0, 6'h20};
    endfunction

    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(pc_addr == 0, "R1 pc", pc_addr, 0);
        chk(ifid_instr == 0, "R1 ifid", ifid_instr, 0);
        chk({idex_mem_rd, idex_mem_wr, idex_reg_wr, idex_mem_to_reg} == 4'b0,
            "R1 ctrl", {idex_mem_rd, idex_mem_wr, idex_reg_wr, idex_mem_to_reg}, 0);
        rst_n = 1'b1;
    endtask

    // kind: 0 load, 1 store, 2 alu producer; consumer is an ALU word
    task automatic run_pair(int kind, int lrt, int drs, int drt);
        logic [31:0] i0, i1;
        bit h;
        i0 = (kind == 0) ? mk_load(6, lrt) : (kind == 1) ? mk_store(6, lrt) : mk_alu(6, lrt);
        i1 = mk_alu(drs, drt);
        for (int k = 0; k < 8; k++) prog[k] = 32'h0;
        prog[0] = i0;
        prog[1] = i1;
        h = (kind == 0) && (lrt == drs || lrt == drt);
        restart();
        @(negedge clk); // cycle 1
        chk(pc_addr == 4, "R6 pc step", pc_addr, 4);
        chk(ifid_instr == i0, "R6 ifid capture", ifid_instr, i0);
        @(negedge clk); // cycle 2: producer in execute, consumer in decode
        chk(idex_mem_rd == (kind == 0), "R7 mem_rd", idex_mem_rd, kind == 0);
        chk(idex_mem_wr == (kind == 1), "R7 mem_wr", idex_mem_wr, kind == 1);
        chk(idex_reg_wr == (kind != 1), "R7 reg_wr", idex_reg_wr, kind != 1);
        chk(idex_mem_to_reg == (kind == 0), "R7 mem_to_reg", idex_mem_to_reg, kind == 0);
        chk(idex_rt == 5'(lrt), "R7 rt", idex_rt, lrt);
        chk(pc_wr_en == !h, "R2 pc_wr_en", pc_wr_en, !h);
        chk(ifid_wr_en == !h, "R2 ifid_wr_en", ifid_wr_en, !h);
        chk(ctrl_zero == h, "R2 ctrl_zero", ctrl_zero, h);
        @(negedge clk); // cycle 3
        chk(pc_addr == (h ? 8 : 12), "R3 pc", pc_addr, h ? 8 : 12);
        chk(ifid_instr == (h ? i1 : 32'h0), "R3 ifid", ifid_instr, h ? i1 : 32'h0);
        chk(idex_reg_wr == !h, "R4 bubble reg_wr", idex_reg_wr, !h);
        chk(idex_mem_rd == 1'b0, "R4 bubble mem_rd", idex_mem_rd, 0);
        chk(pc_wr_en == 1'b1, "R5 no repeat stall", pc_wr_en, 1);
        @(negedge clk); // cycle 4
        chk(pc_addr == (h ? 12 : 16), "R6 pc after", pc_addr, h ? 12 : 16);
        chk(idex_reg_wr == h, "R8 nop decode", idex_reg_wr, h);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 8; k++) prog[k] = 32'h0;
        for (int kind = 0; kind < 3; kind++)
            for (int lrt = 0; lrt < 4; lrt++)
                for (int drs = 0; drs < 4; drs++)
                    for (int drt = 0; drt < 4; drt++)
                        run_pair(kind, lrt, drs, drt);

        // R2: consumer two slots behind the load never stalls
        for (int k = 0; k < 8; k++) prog[k] = 32'h0;
        prog[0] = mk_load(6, 5);
        prog[2] = mk_alu(5, 5);
        restart();
        for (int c = 1; c <= 4; c++) begin
            @(negedge clk);
            chk(pc_wr_en == 1'b1, "R2 distance two", pc_wr_en, 1);
        end
        chk(pc_addr == 16, "R6 distance two pc", pc_addr, 16);

        // R5/R9: chained loads stall twice, never back to back
        for (int k = 0; k < 8; k++) prog[k] = 32'h0;
        prog[0] = mk_load(6, 1);
        prog[1] = mk_load(1, 2);
        prog[2] = mk_alu(2, 7);
        restart();
        @(negedge clk);
        @(negedge clk);
        chk(ctrl_zero == 1'b1, "R9 chain first stall", ctrl_zero, 1);
        @(negedge clk);
        chk(ctrl_zero == 1'b0, "R5 chain refill", ctrl_zero, 0);
        @(negedge clk);
        chk(ctrl_zero == 1'b1, "R9 chain second stall", ctrl_zero, 1);
        @(negedge clk);
        chk(pc_addr == 12, "R3 chain pc", pc_addr, 12);
        chk(ctrl_zero == 1'b0, "R5 chain end", ctrl_zero, 0);

        // R8: unknown opcode yields an empty control word
        for (int k = 0; k < 8; k++) prog[k] = 32'h0;
        prog[0] = {6'd17, 26'h3ff_ffff};
        restart();
        @(negedge clk);
        @(negedge clk);
        chk({idex_mem_rd, idex_mem_wr, idex_reg_wr, idex_mem_to_reg} == 4'b0,
            "R8 unknown opcode", {idex_mem_rd, idex_mem_wr, idex_reg_wr, idex_mem_to_reg}, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule